// File: doc/BRIEF.md
# Peripheral Interrupt Flag Controller

This block collects the interrupt sources of a parallel-interface peripheral into a seven-bit flag register, masks them with a seven-bit enable register, and drives one active-high interrupt request. There are four sources from control lines, two for each port (A and B). Each control line passes through an edge detector. A polarity bit chooses whether that line's rising edge or its falling edge sets the line's flag. The shift-register unit and the two timers deliver one-cycle pulses that set their flags directly.

Software reaches the block through a byte-wide register port with a single select bit. Writing the flag register clears flags. Writing the enable register sets or clears enables, depending on bit 7 of the written byte. Both reads return a synthesized bit 7. The shift-register unit signals its own data reads on a separate strobe, and that strobe clears the shift flag.

Top module: `irq_flag_ctrl`

## Requirements
- R1: `irq` is 1 exactly when some flag bit and its matching enable bit are both 1. It follows a flag or enable change in the same cycle as that change becomes visible.
- R2: A write with `reg_sel`=1 (enable register) and `reg_wdata[7]`=1 ORs `reg_wdata[6:0]` into the enables at the next clock edge.
- R3: A write with `reg_sel`=1 and `reg_wdata[7]`=0 clears each enable whose bit in `reg_wdata[6:0]` is 1. All other enables are unchanged.
- R4: With `reg_sel`=1, `reg_rdata` is {1'b1, enables[6:0]}.
- R5: With `reg_sel`=0, `reg_rdata` is {any enabled flag pending, flags[6:0]}.
- R6: A write with `reg_sel`=0 clears each flag whose bit in `reg_wdata[6:0]` is 1. All other flags are unchanged.
- R7: Control-line flags sit at these bits: port A line 2 at bit 0, port A line 1 at bit 1, port B line 2 at bit 3, port B line 1 at bit 4. The polarity for each line is `ctl_pol` bit 0, 1, 2 and 3 in that same order. With polarity 1 a rising edge sets the flag; with polarity 0 a falling edge sets it. The opposite edge and a steady level leave the flag unchanged.
- R8: Each cycle in which `shift_done` is high sets flag bit 2, with no edge detection. A `shift_rd` pulse clears flag bit 2.
- R9: A `tmr2_done` pulse sets flag bit 5. A `tmr1_done` pulse sets flag bit 6.
- R10: When a set and a clear reach the same flag in the same cycle, the flag ends up set.
- R11: Synchronous reset (`rst_n` low at a clock edge) clears flags and enables. A control line that is held at the active level through reset does not set its flag when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_a1 | input | 1 | Port A control line 1 |
| ctl_a2 | input | 1 | Port A control line 2 |
| ctl_b1 | input | 1 | Port B control line 1 |
| ctl_b2 | input | 1 | Port B control line 2 |
| ctl_pol | input | 4 | Edge polarity per line: bit0 A2, bit1 A1, bit2 B2, bit3 B1 (1 = rising) |
| shift_done | input | 1 | Shift-complete pulse |
| shift_rd | input | 1 | Shift data read strobe, clears the shift flag |
| tmr1_done | input | 1 | Timer 1 expiry pulse |
| tmr2_done | input | 1 | Timer 2 expiry pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = flag register, 1 = enable register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register (combinational) |
| irq | output | 1 | Interrupt request, active high |

## Verification
Every state change takes effect at the first clock edge after the stimulus is presented. This covers a control-line transition, a source pulse, a register write and a shift read. The new flag or enable value, and the `irq` and `reg_rdata` values derived from it, can be observed right after that edge. The bench changes inputs at the falling edge, lets exactly one rising edge pass, and samples at the next falling edge. Because `reg_rdata` is combinational, a read is set up by changing `reg_sel` away from the edge and sampling one nanosecond later. To confirm that a steady level or an opposite edge has no effect, the bench waits several extra cycles before reading.

// File: rtl/irqfc_pkg.sv
// Shared constants for the interrupt flag controller: register widths,
// register-select codes and the flag bit map.
package irqfc_pkg;
    localparam int REG_W  = 8;
    localparam int SRC_W  = REG_W - 1;
    localparam int LINE_N = 4;

    localparam logic SEL_FLAG = 1'b0;
    localparam logic SEL_ENAB = 1'b1;

    localparam int FB_A2  = 0;
    localparam int FB_A1  = 1;
    localparam int FB_SH  = 2;
    localparam int FB_B2  = 3;
    localparam int FB_B1  = 4;
    localparam int FB_T2  = 5;
    localparam int FB_T1  = 6;
endpackage

// File: rtl/irqfc_edge.sv
// Edge detector with per-line polarity selection.
// Assumes the inputs are already synchronous to clk. The previous level
// register is loaded during reset too, so a level held through reset
// produces no edge when reset is released.
module irqfc_edge #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    input  logic [N-1:0] pol,
    output logic [N-1:0] hit
);
    logic [N-1:0] prev;

    // Track last sampled level; reset also tracks to avoid a false edge.
    always_ff @(posedge clk) begin
        prev <= lvl;
    end

    for (genvar i = 0; i < N; i++) begin : g_line
        assign hit[i] = (lvl[i] ^ prev[i]) & ~(lvl[i] ^ pol[i]);

        // R7: a detected edge implies the level actually moved since last cycle
        a_r7_edge_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |-> (lvl[i] != $past(lvl[i])));
    end
endmodule

// File: rtl/irqfc_flags.sv
// Flag register: sticky bits with per-bit set and clear, set has priority.
// Assumes set_vec and clr_vec are single-cycle strobes from the parent.
module irqfc_flags #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] flags
);
    // Update flags: clear first, then OR in sets so a set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_vec) | set_vec;
    end

    for (genvar i = 0; i < W; i++) begin : g_chk
        // R10: a set in the same cycle as a clear leaves the flag set
        a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> flags[i]);
        // R6: a clear without a set drops the flag
        a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[i] && !set_vec[i]) |=> !flags[i]);
        // R6: without a clear a pending flag stays pending
        a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !clr_vec[i]) |=> flags[i]);
    end
endmodule

// File: rtl/irqfc_enables.sv
// Enable register written in set/clear fashion: the top data bit picks
// whether the low bits are ORed in or cleared out.
// Assumes wdata is stable in the cycle wr is high.
module irqfc_enables #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W:0]   wdata,
    output logic [W-1:0] en
);
    // Apply set-mode or clear-mode write to the enables.
    always_ff @(posedge clk) begin
        if (!rst_n)       en <= '0;
        else if (wr) begin
            if (wdata[W]) en <= en | wdata[W-1:0];
            else          en <= en & ~wdata[W-1:0];
        end
    end

    // R2: set-mode write leaves every written bit enabled
    a_r2_set_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wdata[W]) |=> ((en & $past(wdata[W-1:0])) == $past(wdata[W-1:0])));
    // R3: clear-mode write leaves every written bit disabled
    a_r3_clear_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !wdata[W]) |=> ((en & $past(wdata[W-1:0])) == '0));
    // R3: enables hold when not written
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(en));
endmodule

// File: rtl/irq_flag_ctrl.sv
// Interrupt flag controller top: maps control-line edges, shift and timer
// pulses onto flag bits, decodes the register port, and forms the request.
// Assumes all inputs are synchronous to clk; reg_rdata is combinational.
module irq_flag_ctrl
    import irqfc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_a1,
    input  logic             ctl_a2,
    input  logic             ctl_b1,
    input  logic             ctl_b2,
    input  logic [LINE_N-1:0] ctl_pol,
    input  logic             shift_done,
    input  logic             shift_rd,
    input  logic             tmr1_done,
    input  logic             tmr2_done,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq
);
    logic [LINE_N-1:0] line_lvl;
    logic [LINE_N-1:0] line_hit;
    logic [SRC_W-1:0]  set_vec;
    logic [SRC_W-1:0]  clr_vec;
    logic [SRC_W-1:0]  flags;
    logic [SRC_W-1:0]  enab;
    logic              pending;

    assign line_lvl = {ctl_b1, ctl_b2, ctl_a1, ctl_a2};

    irqfc_edge #(.N(LINE_N)) edge_i (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (line_lvl),
        .pol  (ctl_pol),
        .hit  (line_hit)
    );

    // Route every source onto its flag bit.
    always_comb begin
        set_vec         = '0;
        set_vec[FB_A2]  = line_hit[0];
        set_vec[FB_A1]  = line_hit[1];
        set_vec[FB_B2]  = line_hit[2];
        set_vec[FB_B1]  = line_hit[3];
        set_vec[FB_SH]  = shift_done;
        set_vec[FB_T2]  = tmr2_done;
        set_vec[FB_T1]  = tmr1_done;
    end

    // Gather clears from flag-register writes and shift data reads.
    always_comb begin
        clr_vec = '0;
        if (reg_wr && (reg_sel == SEL_FLAG)) clr_vec = reg_wdata[SRC_W-1:0];
        if (shift_rd)                       clr_vec[FB_SH] = 1'b1;
    end

    irqfc_flags #(.W(SRC_W)) flags_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_vec(set_vec),
        .clr_vec(clr_vec),
        .flags  (flags)
    );

    irqfc_enables #(.W(SRC_W)) enab_i (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (reg_wr && (reg_sel == SEL_ENAB)),
        .wdata(reg_wdata),
        .en   (enab)
    );

    assign pending = |(flags & enab);
    assign irq     = pending;

    // Read mux with synthesized top bit.
    always_comb begin
        if (reg_sel == SEL_ENAB) reg_rdata = {1'b1, enab};
        else                     reg_rdata = {pending, flags};
    end

    // R5: flag read top bit agrees with the request line
    a_r5_top_bit_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == SEL_FLAG) |-> (reg_rdata[REG_W-1] == irq));
    // R4: enable read always shows the top bit
    a_r4_enab_top: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == SEL_ENAB) |-> reg_rdata[REG_W-1]);
    // R1: with no enables the request stays low
    a_r1_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (enab == '0) |-> !irq);
    // R8: a shift-done pulse leaves the shift flag set
    a_r8_shift_sets: assert property (@(posedge clk) disable iff (!rst_n)
        shift_done |=> flags[FB_SH]);
endmodule

// File: tb/irq_flag_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_flag_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_a1 = 1'b0, ctl_a2 = 1'b0, ctl_b1 = 1'b0, ctl_b2 = 1'b0;
    logic [3:0] ctl_pol = 4'h0;
    logic       shift_done = 1'b0, shift_rd = 1'b0;
    logic       tmr1_done = 1'b0, tmr2_done = 1'b0;
    logic       reg_wr = 1'b0, reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_flag_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .ctl_a1(ctl_a1), .ctl_a2(ctl_a2), .ctl_b1(ctl_b1), .ctl_b2(ctl_b2),
        .ctl_pol(ctl_pol), .shift_done(shift_done), .shift_rd(shift_rd),
        .tmr1_done(tmr1_done), .tmr2_done(tmr2_done),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic sel, input logic [7:0] d);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic rd_reg(input logic sel, output logic [7:0] d);
        reg_sel = sel;
        #1;
        d = reg_rdata;
    endtask

    task automatic set_line(input int idx, input logic v);
        case (idx)
            0: ctl_a2 = v;
            1: ctl_a1 = v;
            2: ctl_b2 = v;
            default: ctl_b1 = v;
        endcase
    endtask

    task automatic t_reset();
        logic [7:0] d;
        ctl_a1 = 1'b1; ctl_pol = 4'b0010;   // A1 active-high held through reset
        repeat (3) tick();
        rst_n = 1'b1;
        repeat (3) tick();
        rd_reg(1'b0, d); chk("R11 flags after reset, line held", d, 8'h00);
        rd_reg(1'b1, d); chk("R11 enables after reset", d, 8'h80);
        chk("R11 irq after reset", irq, 0);
        ctl_a1 = 1'b0; tick();
        ctl_pol = 4'h0;
        rd_reg(1'b0, d); chk("R7 falling edge ignored with rising polarity", d, 8'h00);
    endtask

    task automatic t_enables();
        logic [7:0] d;
        wr_reg(1'b1, 8'h85);
        rd_reg(1'b1, d); chk("R2 set mode", d, 8'h85);
        wr_reg(1'b1, 8'hC2);
        rd_reg(1'b1, d); chk("R2 set mode ORs", d, 8'hC7);
        wr_reg(1'b1, 8'h03);
        rd_reg(1'b1, d); chk("R3 clear mode", d, 8'hC4);
        wr_reg(1'b1, 8'h7F);
        rd_reg(1'b1, d); chk("R4 top bit with all clear", d, 8'h80);
    endtask

    task automatic t_lines();
        logic [7:0] d;
        int bitpos[4] = '{0, 1, 3, 4};
        // falling polarity on all lines: rising edges do nothing
        ctl_pol = 4'h0;
        for (int i = 0; i < 4; i++) set_line(i, 1'b1);
        repeat (3) tick();
        rd_reg(1'b0, d); chk("R7 rising ignored with falling polarity", d, 8'h00);
        for (int i = 0; i < 4; i++) set_line(i, 1'b0);
        tick();
        rd_reg(1'b0, d); chk("R7 falling edges set", d, 8'h1B);
        wr_reg(1'b0, 8'h1B);
        rd_reg(1'b0, d); chk("R6 clear line flags", d, 8'h00);
        // rising polarity, one line at a time
        ctl_pol = 4'hF;
        for (int i = 0; i < 4; i++) begin
            set_line(i, 1'b1);
            tick();
            rd_reg(1'b0, d); chk("R7 single rising edge bit", d, 1 << bitpos[i]);
            wr_reg(1'b0, 8'h7F);
        end
        repeat (3) tick();
        rd_reg(1'b0, d); chk("R7 steady high no re-set", d, 8'h00);
        for (int i = 0; i < 4; i++) set_line(i, 1'b0);
        repeat (2) tick();
        rd_reg(1'b0, d); chk("R7 falling ignored with rising polarity", d, 8'h00);
    endtask

    task automatic t_shift();
        logic [7:0] d;
        shift_done = 1'b1; tick();
        rd_reg(1'b0, d); chk("R8 shift pulse sets bit2", d, 8'h04);
        shift_rd = 1'b1; tick();              // pulse still high: set wins
        rd_reg(1'b0, d); chk("R10 set beats shift read clear", d, 8'h04);
        shift_done = 1'b0; tick();
        shift_rd = 1'b0;
        rd_reg(1'b0, d); chk("R8 shift read clears bit2", d, 8'h00);
        shift_done = 1'b1; tick(); shift_done = 1'b0;
        rd_reg(1'b0, d); chk("R8 next pulse sets again", d, 8'h04);
        tmr1_done = 1'b1; reg_sel = 1'b0; reg_wdata = 8'h40; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0; tmr1_done = 1'b0;
        rd_reg(1'b0, d); chk("R10 timer set beats flag write clear", d, 8'h44);
        wr_reg(1'b0, 8'h44);
    endtask

    task automatic t_timers_irq();
        logic [7:0] d;
        tmr1_done = 1'b1; tick(); tmr1_done = 1'b0;
        rd_reg(1'b0, d); chk("R9 timer1 sets bit6", d, 8'h40);
        tmr2_done = 1'b1; tick(); tmr2_done = 1'b0;
        rd_reg(1'b0, d); chk("R9 timer2 sets bit5", d, 8'h60);
        wr_reg(1'b0, 8'h20);
        rd_reg(1'b0, d); chk("R6 clears only written bit", d, 8'h40);
        chk("R1 irq low when not enabled", irq, 0);
        wr_reg(1'b1, 8'hC0);
        chk("R1 irq high when enabled", irq, 1);
        rd_reg(1'b0, d); chk("R5 flag read top bit set", d, 8'hC0);
        wr_reg(1'b1, 8'h40);
        chk("R1 irq drops when disabled", irq, 0);
        rd_reg(1'b0, d); chk("R5 flag read top bit clear", d, 8'h40);
        wr_reg(1'b1, 8'h80 | 8'h40);
        wr_reg(1'b0, 8'h40);
        chk("R1 irq drops when flag cleared", irq, 0);
        rd_reg(1'b1, d); chk("R4 enable read", d, 8'hC0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_enables();
        t_lines();
        t_shift();
        t_timers_irq();
        done = 1;
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end
endmodule